// File: doc/BRIEF.md
# Cell receive port for a multi-PHY slave

This block is the receive side of a slave port on a cell bus. An external master polls a set of PHY ports by address. It reads back a cell-available flag, then pushes a fixed-length cell into the selected port one word per enabled clock. Each word carries an odd parity bit. The port knows its own 5-bit identity from a static input and answers a poll only when the polled address equals that identity. At any other time it keeps its cell-available output disabled.

Incoming words are framed by the start-of-cell flag and counted up to the cell length. The cell length is 53 words on an 8-bit bus and 27 words on a 16-bit bus, where the first word carries header padding. Each word is written into one of two cell slots. A cell becomes visible on the output side only after its last word has arrived and the whole cell has passed the parity check. Cells with a parity error are discarded when checking is on. So are cells cut short by a new start-of-cell, and cells that begin while both slots are occupied. Stored cells leave in arrival order over a word-wide valid/ready stream with first-word and last-word markers.

Top module: `cellrx_slave_rx`

## Requirements
- R1: A word is accepted only on a rising clock edge where `rx_enb` is high and `rx_addr` equals `phy_id`. Words seen with `rx_enb` low or with any other address leave the stored and emitted data unchanged.
- R2: A word passes the parity test when `rx_data` together with `rx_par` holds an odd number of ones.
- R3: When `chk_en` is high, a cell that contains any word failing the R2 test is discarded as a whole. When `chk_en` is low, such a cell is delivered unchanged.
- R4: A cell is 53 accepted words long when DATA_W is 8 and 27 words long when DATA_W is 16. The count starts at the word accepted with `rx_soc` high.
- R5: An accepted word with `rx_soc` high that arrives while a cell is still incomplete discards the partial cell and starts a new one. `runt_err` is high for exactly the one cycle after that edge.
- R6: A cell appears at the output only after all of its words have been received. `out_sop` marks its first word and `out_eop` its last. A word moves on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid`, `out_data`, `out_sop` and `out_eop` hold.
- R7: `clav_oe` is high in the cycle after an edge where `rx_addr` equalled `phy_id`, and low otherwise. `clav` is never high while `clav_oe` is low.
- R8: `clav` is high after an addressed edge only if stored cells plus a cell in progress number fewer than two. With two cells stored, `clav` is low.
- R9: A cell whose first word is accepted while both slots are occupied is discarded, even if a slot frees before it ends.
- R10: Accepted words with `rx_soc` low that arrive outside a cell are ignored.
- R11: After reset, `clav`, `clav_oe`, `runt_err`, `out_valid`, `out_sop` and `out_eop` are low.
- R12: Delivered cells leave in the order they were completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| phy_id | input | 5 | Programmed identity of this port |
| chk_en | input | 1 | 1 = discard cells with parity errors |
| rx_addr | input | 5 | Address polled or selected by the master |
| rx_data | input | DATA_W | Cell word from the master, bit 0 lsb |
| rx_soc | input | 1 | First word of a cell |
| rx_enb | input | 1 | Master strobe: word on the bus is valid |
| rx_par | input | 1 | Odd parity bit over rx_data |
| clav | output | 1 | Room for a whole cell (meaningful when clav_oe is high) |
| clav_oe | output | 1 | Drive enable for clav; low acts as high impedance |
| runt_err | output | 1 | One-cycle pulse when a partial cell is cut off |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DATA_W | Output word |
| out_sop | output | 1 | Output word is the first of a cell |
| out_eop | output | 1 | Output word is the last of a cell |

## Verification
A wrong word counter moves `out_eop` off the 53rd word of the next delivered cell. It also lets a cut-off cell leak out, and the word-by-word scoreboard catches that on the first wrong word. A wrong slot occupancy shows within one poll as `clav` staying high with two cells held, or as a third cell being delivered. A stuck error flag shows as a good cell never leaving. Each of these is visible a few cycles after the cell boundary where the fault arises.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

  localparam int unsigned SLOT_COUNT = 2;
  localparam int unsigned ID_W       = 5;

  // Cell length in bus words: a 16-bit bus pads the header's first word.
  function automatic int unsigned cell_words(input int unsigned bus_w);
    return (bus_w == 16) ? 27 : 53;
  endfunction

  // Odd parity across data and parity bit means the word is clean.
  function automatic logic parity_ok(input logic [15:0] word, input logic par);
    return (^word) ^ par;
  endfunction

  // True when the held plus in-flight cells leave room for one more.
  function automatic logic has_room(input logic [1:0] held, input logic filling);
    return ({1'b0, held} + {2'b00, filling}) < 3'(SLOT_COUNT);
  endfunction

endpackage

// File: rtl/cellrx_addr_poll.sv
module cellrx_addr_poll
  import cellrx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] rx_addr,
  input  logic [ID_W-1:0] phy_id,
  input  logic            room,
  output logic            hit,
  output logic            clav,
  output logic            clav_oe
);

  assign hit = (rx_addr == phy_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clav    <= 1'b0;
      clav_oe <= 1'b0;
    end else begin
      clav_oe <= hit;
      clav    <= hit & room;
    end
  end

endmodule

// File: rtl/cellrx_framer.sv
module cellrx_framer
  import cellrx_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 53,
  parameter int unsigned IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enb,
  input  logic          rx_soc,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_par,
  input  logic          hit,
  input  logic          chk_en,
  input  logic          slot_free,
  output logic          acc,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          commit,
  output logic          busy,
  output logic          runt_err
);

  logic          in_cell;
  logic          ovf;
  logic          bad;
  logic [IW-1:0] cnt;
  logic          start_evt;
  logic          cont_evt;
  logic          last_evt;
  logic          word_err;

  assign acc       = rx_enb & hit;
  assign start_evt = acc & rx_soc;
  assign cont_evt  = acc & ~rx_soc & in_cell;
  assign last_evt  = cont_evt & (cnt == IW'(CW - 1));
  assign word_err  = chk_en & ~parity_ok(16'(rx_data), rx_par);

  assign wr_en   = (start_evt & slot_free) | (cont_evt & ~ovf);
  assign wr_idx  = start_evt ? '0 : cnt;
  assign wr_data = rx_data;
  assign commit  = last_evt & ~ovf & ~(bad | word_err);
  assign busy    = in_cell & ~ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cell  <= 1'b0;
      ovf      <= 1'b0;
      bad      <= 1'b0;
      cnt      <= '0;
      runt_err <= 1'b0;
    end else begin
      runt_err <= start_evt & in_cell;
      if (start_evt) begin
        in_cell <= 1'b1;
        ovf     <= ~slot_free;
        bad     <= word_err;
        cnt     <= IW'(1);
      end else if (cont_evt) begin
        bad <= bad | word_err;
        if (last_evt) begin
          in_cell <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + IW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/cellrx_store.sv
module cellrx_store
  import cellrx_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 53,
  parameter int unsigned IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic [1:0]    occ,
  output logic          slot_free,
  output logic          release_evt
);

  localparam int unsigned DEPTH = SLOT_COUNT * CW;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic          wr_slot;
  logic          rd_slot;
  logic [IW-1:0] rd_idx;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          take;

  assign wr_addr = wr_slot ? AW'(CW) + AW'(wr_idx) : AW'(wr_idx);
  assign rd_addr = rd_slot ? AW'(CW) + AW'(rd_idx) : AW'(rd_idx);

  assign out_valid   = (occ != 2'd0);
  assign out_data    = mem[rd_addr];
  assign out_sop     = out_valid & (rd_idx == '0);
  assign out_eop     = out_valid & (rd_idx == IW'(CW - 1));
  assign take        = out_valid & out_ready;
  assign release_evt = take & (rd_idx == IW'(CW - 1));
  assign slot_free   = (occ < 2'(SLOT_COUNT));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot <= 1'b0;
      rd_slot <= 1'b0;
      rd_idx  <= '0;
      occ     <= '0;
    end else begin
      if (commit) wr_slot <= ~wr_slot;
      if (take) begin
        if (release_evt) begin
          rd_idx  <= '0;
          rd_slot <= ~rd_slot;
        end else begin
          rd_idx <= rd_idx + IW'(1);
        end
      end
      occ <= occ + 2'(commit) - 2'(release_evt);
    end
  end

endmodule

// File: rtl/cellrx_slave_rx.sv
module cellrx_slave_rx
  import cellrx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        phy_id,
  input  logic              chk_en,
  input  logic [4:0]        rx_addr,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_soc,
  input  logic              rx_enb,
  input  logic              rx_par,
  output logic              clav,
  output logic              clav_oe,
  output logic              runt_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);

  localparam int unsigned CW = cell_words(DATA_W);
  localparam int unsigned IW = $clog2(CW);

  logic              hit;
  logic              room;
  logic              acc_evt;
  logic              wr_en;
  logic [IW-1:0]     wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              commit_evt;
  logic              busy;
  logic [1:0]        occ;
  logic              slot_free;
  logic              release_evt;

  assign room = has_room(occ, busy);

  cellrx_addr_poll u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_addr (rx_addr),
    .phy_id  (phy_id),
    .room    (room),
    .hit     (hit),
    .clav    (clav),
    .clav_oe (clav_oe)
  );

  cellrx_framer #(.DW(DATA_W), .CW(CW), .IW(IW)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_enb    (rx_enb),
    .rx_soc    (rx_soc),
    .rx_data   (rx_data),
    .rx_par    (rx_par),
    .hit       (hit),
    .chk_en    (chk_en),
    .slot_free (slot_free),
    .acc       (acc_evt),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .commit    (commit_evt),
    .busy      (busy),
    .runt_err  (runt_err)
  );

  cellrx_store #(.DW(DATA_W), .CW(CW), .IW(IW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .commit      (commit_evt),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .occ         (occ),
    .slot_free   (slot_free),
    .release_evt (release_evt)
  );

endmodule

// File: rtl/cellrx_checks.sv
module cellrx_checks #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_enb,
  input logic          rx_soc,
  input logic [4:0]    rx_addr,
  input logic [4:0]    phy_id,
  input logic          runt_err,
  input logic          clav,
  input logic          clav_oe,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sop,
  input logic          out_eop,
  input logic [1:0]    occ,
  input logic          commit_evt,
  input logic          release_evt
);

  a_r7_clav_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    clav |-> clav_oe);

  a_r7_oe_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_addr == phy_id) |=> clav_oe);

  a_r5_runt_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    runt_err |-> $past(rx_enb && rx_soc && (rx_addr == phy_id)));

  a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sop) && $stable(out_eop)));

  a_r6_markers_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid);

  a_r8_full_no_clav: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 2'd2) |=> !clav);

  a_r9_no_commit_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (occ != 2'd2 || release_evt));

  a_r6_release_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |-> (out_eop && out_ready));

endmodule

bind cellrx_slave_rx cellrx_checks #(.DW(DATA_W)) i_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_enb      (rx_enb),
  .rx_soc      (rx_soc),
  .rx_addr     (rx_addr),
  .phy_id      (phy_id),
  .runt_err    (runt_err),
  .clav        (clav),
  .clav_oe     (clav_oe),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_sop     (out_sop),
  .out_eop     (out_eop),
  .occ         (occ),
  .commit_evt  (commit_evt),
  .release_evt (release_evt)
);

// File: tb/test_cellrx_slave_rx.sv
module test_cellrx_slave_rx;

  localparam int DW    = 8;
  localparam int CWORD = 53;
  localparam logic [4:0] MY_ID = 5'd9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [4:0]    phy_id;
  logic          chk_en;
  logic [4:0]    rx_addr;
  logic [DW-1:0] rx_data;
  logic          rx_soc;
  logic          rx_enb;
  logic          rx_par;
  logic          clav;
  logic          clav_oe;
  logic          runt_err;
  logic          out_valid;
  logic          out_ready;
  logic [DW-1:0] out_data;
  logic          out_sop;
  logic          out_eop;

  int total = 0;
  int bad   = 0;
  int runt_cnt = 0;
  int pos = 0;
  logic [DW-1:0] exp_q[$];

  always #2 clk = ~clk;

  cellrx_slave_rx #(.DATA_W(DW)) i_cellrx_slave_rx (
    .clk(clk), .rst_n(rst_n), .phy_id(phy_id), .chk_en(chk_en),
    .rx_addr(rx_addr), .rx_data(rx_data), .rx_soc(rx_soc), .rx_enb(rx_enb),
    .rx_par(rx_par), .clav(clav), .clav_oe(clav_oe), .runt_err(runt_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int tag, input int i);
    return DW'((tag * 37 + i * 11 + 5) % 256);
  endfunction

  // Output scoreboard (R6, R12) and runt pulse counter (R5)
  always @(negedge clk) begin
    if (rst_n) begin
      if (runt_err) runt_cnt++;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R9 unexpected word", int'(out_data), -1);
        end else begin
          check(out_data == exp_q[0], "R6/R12 data", int'(out_data), int'(exp_q[0]));
          check(out_sop == (pos == 0), "R6 sop", int'(out_sop), int'(pos == 0));
          check(out_eop == (pos == CWORD - 1), "R4/R6 eop", int'(out_eop), int'(pos == CWORD - 1));
          void'(exp_q.pop_front());
          pos = (pos == CWORD - 1) ? 0 : pos + 1;
        end
      end
    end
  end

  task automatic put_word(input logic [DW-1:0] d, input bit soc, input bit perr);
    @(posedge clk); #1;
    rx_addr = MY_ID;
    rx_enb  = 1'b1;
    rx_soc  = soc;
    rx_data = d;
    rx_par  = perr ? (^d) : ~(^d);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    rx_enb = 1'b0;
    rx_soc = 1'b0;
  endtask

  task automatic send_cell(input int tag, input int nw, input int err_at,
                           input bit gaps, input bit expect_it);
    if (expect_it)
      for (int i = 0; i < CWORD; i++) exp_q.push_back(word_of(tag, i));
    for (int i = 0; i < nw; i++) begin
      put_word(word_of(tag, i), i == 0, i == err_at);
      if (gaps && (i % 3 == 1)) begin
        @(posedge clk); #1;
        rx_enb = 1'b0; rx_soc = 1'b1; rx_data = 8'hAA;   // R1: enable low
        @(posedge clk); #1;
        rx_enb = 1'b1; rx_addr = 5'd3; rx_soc = 1'b1;    // R1: other address
      end
    end
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rb;
    rst_n = 1'b0; phy_id = MY_ID; chk_en = 1'b1; rx_addr = 5'd0;
    rx_data = '0; rx_soc = 1'b0; rx_enb = 1'b0; rx_par = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({clav, clav_oe, runt_err, out_valid, out_sop, out_eop} == 6'b0,
          "R11 reset outputs", int'({clav, clav_oe, runt_err, out_valid, out_sop, out_eop}), 0);
    rst_n = 1'b1;

    // R7: sweep every address
    for (int a = 0; a < 32; a++) begin
      @(posedge clk); #1; rx_addr = 5'(a);
      @(posedge clk); @(negedge clk);
      check(clav_oe == (a == MY_ID), "R7 clav_oe", int'(clav_oe), int'(a == MY_ID));
      check(clav == (a == MY_ID), "R7/R8 clav", int'(clav), int'(a == MY_ID));
    end

    send_cell(1, CWORD, -1, 1'b0, 1'b1);               // R4 R6 R2
    for (int i = 0; i < 5; i++) put_word(8'h55, 1'b0, 1'b0); // R10 stray words
    idle();
    send_cell(2, CWORD, -1, 1'b1, 1'b1);               // R1 gaps and foreign address
    send_cell(3, CWORD, 20, 1'b0, 1'b0);               // R3 error dropped
    send_cell(4, CWORD, -1, 1'b0, 1'b1);
    chk_en = 1'b0;
    send_cell(5, CWORD, 7, 1'b0, 1'b1);                // R3 check off: kept
    chk_en = 1'b1;

    rb = runt_cnt;
    send_cell(6, 10, -1, 1'b0, 1'b0);                  // R5 partial, cut off
    send_cell(7, CWORD, -1, 1'b0, 1'b1);
    repeat (2) @(posedge clk);
    check(runt_cnt - rb == 1, "R5 runt pulse count", runt_cnt - rb, 1);

    repeat (120) @(posedge clk);
    check(exp_q.size() == 0, "R6 drained before full test", exp_q.size(), 0);

    // R8 R9: fill both slots with output stalled
    #1 out_ready = 1'b0;
    send_cell(8, CWORD, -1, 1'b0, 1'b1);
    send_cell(9, CWORD, -1, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid && out_sop && out_data == word_of(8, 0), "R6 hold while stalled",
            int'(out_data), int'(word_of(8, 0)));
    end
    @(posedge clk); @(negedge clk);
    check(clav == 1'b0, "R8 clav low when full", int'(clav), 0);
    check(clav_oe == 1'b1, "R7 oe while addressed", int'(clav_oe), 1);
    send_cell(10, CWORD, -1, 1'b0, 1'b0);              // R9 dropped
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (200) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R12 all expected cells delivered", exp_q.size(), 0);
    check(clav == 1'b1, "R8 clav back after drain", int'(clav), 1);
    check(runt_cnt == 1, "R5 no stray runt", runt_cnt, 1);
    check(out_valid == 1'b0, "R9 nothing extra stored", int'(out_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule